// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoints

This block renames registers for an out-of-order core that has more physical registers than architectural ones. A table maps each architectural register to the physical register that holds its newest value. A bit mask records which physical registers are unused. Every instruction that writes a register is given a fresh physical register. The response also returns the physical register that the destination used before, so the commit stage can free it once the instruction retires.

When a branch enters rename, the block saves a full copy of the map in a free checkpoint slot. From then on it records every physical register that is allocated while that checkpoint is live. If the branch resolves as mispredicted, the saved map is put back in a single cycle. Every register allocated since the checkpoint returns to the free mask, and that checkpoint and all younger ones are released. If the branch resolves correctly, only its own checkpoint is released. The reorder buffer and the execution units sit outside this block.

Top module: `rename_ckpt_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers ARCH_REGS..PHYS_REGS-1 are free, and no response or acknowledge is pending.
- R2: Both sources of a rename are translated through the map as it stood before this request's own destination update, so a source equal to the destination returns the old mapping.
- R3: An accepted rename produces a response exactly one cycle later. For a writing rename, rsp_dst is the lowest-numbered free physical register, rsp_old is the previous mapping of the destination, and rsp_dst_vld is 1. For a non-writing rename all three are 0.
- R4: A writing rename is refused (ren_ready low) while no physical register is free. A non-writing rename is still accepted.
- R5: A register named on the commit-free port becomes allocatable from the next cycle.
- R6: A branch is accepted only while a checkpoint slot is free (br_ready low when all NUM_CKPT are in use). One cycle after acceptance, br_ack_valid pulses with the tag of the lowest free slot.
- R7: On a mispredict for tag t, the map returns to its state when t was taken. A rename accepted in the same cycle as the branch counts as older than the branch.
- R8: On a mispredict for tag t, every physical register allocated since t was taken becomes free again. Checkpoint t and all checkpoints taken after it are released.
- R9: A correct resolve of tag t releases slot t alone. That slot may then be given to a later branch.
- R10: In a cycle with a mispredict, neither ren_ready nor br_ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_wr | input | 1 | Request has a destination register |
| ren_src1 | input | $clog2(ARCH_REGS) | First source, architectural |
| ren_src2 | input | $clog2(ARCH_REGS) | Second source, architectural |
| ren_dst | input | $clog2(ARCH_REGS) | Destination, architectural |
| ren_ready | output | 1 | Rename request accepted this cycle |
| rsp_valid | output | 1 | Rename response present |
| rsp_src1 | output | $clog2(PHYS_REGS) | First source, physical |
| rsp_src2 | output | $clog2(PHYS_REGS) | Second source, physical |
| rsp_dst_vld | output | 1 | Response carries a new destination |
| rsp_dst | output | $clog2(PHYS_REGS) | Newly allocated physical register |
| rsp_old | output | $clog2(PHYS_REGS) | Previous mapping, to be freed at commit |
| free_valid | input | 1 | Commit frees a physical register |
| free_preg | input | $clog2(PHYS_REGS) | Register being freed |
| br_valid | input | 1 | Branch requests a checkpoint |
| br_ready | output | 1 | Checkpoint taken this cycle |
| br_ack_valid | output | 1 | Checkpoint tag is valid |
| br_ack_tag | output | $clog2(NUM_CKPT) | Slot given to the branch |
| res_valid | input | 1 | A branch resolves |
| res_tag | input | $clog2(NUM_CKPT) | Slot of the resolving branch |
| res_mispred | input | 1 | Resolve is a misprediction |

## Verification
The bench builds the block with its defaults: 32 architectural registers, 64 physical registers and 4 checkpoints. With only 32 spare registers, a single run of renames drains the free mask, so the refusal of R4 is reached in a few dozen cycles. With 4 slots, a fifth branch reaches the full-checkpoint stall of R6. Random phases that restart from reset mix nested branches, out-of-order correct resolves and mispredicts of middle checkpoints, so the younger-slot release and mask reclaim of R8 are exercised with several checkpoints live.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int unsigned DEF_ARCH = 32;
  localparam int unsigned DEF_PHYS = 64;
  localparam int unsigned DEF_CKPT = 4;
endpackage

// File: rtl/rmap_lowest_pick.sv
// Lowest set bit of a request vector: one-hot, index and any flag.
module rmap_lowest_pick #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  hot,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign hot = req & (~req + W'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rmap_freelist.sv
// Free mask of physical registers with lowest-first allocation.
module rmap_freelist #(
  parameter int unsigned ARCH = 32,
  parameter int unsigned PHYS = 64,
  localparam int unsigned PW  = $clog2(PHYS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PHYS-1:0] give_hot,
  input  logic [PHYS-1:0] reclaim,
  output logic [PW-1:0]   pick_idx,
  output logic [PHYS-1:0] pick_hot,
  output logic            pick_any,
  output logic [PHYS-1:0] free_mask
);
  logic [PHYS-1:0] free_q;

  rmap_lowest_pick #(.W(PHYS)) u_pick (
    .req (free_q),
    .hot (pick_hot),
    .idx (pick_idx),
    .any (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS; i++) free_q[i] <= (i >= ARCH);
    end else begin
      free_q <= (free_q & ~(take ? pick_hot : '0)) | give_hot | reclaim;
    end
  end

  assign free_mask = free_q;
endmodule

// File: rtl/rmap_ckpt_bank.sv
// Branch checkpoint slots: saved map, allocated-since mask, age relation.
module rmap_ckpt_bank #(
  parameter int unsigned ARCH = 32,
  parameter int unsigned PHYS = 64,
  parameter int unsigned NCK  = 4,
  localparam int unsigned PW  = $clog2(PHYS),
  localparam int unsigned CW  = $clog2(NCK),
  localparam int unsigned MW  = ARCH * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [MW-1:0]   snap_map,
  input  logic [PHYS-1:0] alloc_hot,
  input  logic            res_valid,
  input  logic [CW-1:0]   res_tag,
  input  logic            res_mispred,
  output logic            slot_any,
  output logic [CW-1:0]   slot_idx,
  output logic [MW-1:0]   restore_map,
  output logic [PHYS-1:0] reclaim,
  output logic [NCK-1:0]  active
);
  logic [NCK-1:0]  act_q;
  logic [NCK-1:0]  slot_hot;
  logic [PHYS-1:0] mask_q [NCK];
  logic [MW-1:0]   map_q  [NCK];
  logic [NCK-1:0]  yng_q  [NCK];

  rmap_lowest_pick #(.W(NCK)) u_slot (
    .req (~act_q),
    .hot (slot_hot),
    .idx (slot_idx),
    .any (slot_any)
  );

  assign restore_map = map_q[res_tag];
  assign reclaim     = (res_valid && res_mispred) ? mask_q[res_tag] : '0;
  assign active      = act_q;

  for (genvar i = 0; i < NCK; i++) begin : g_slot
    logic kill_i, new_i;
    assign new_i  = take && slot_hot[i];
    assign kill_i = res_valid &&
                    ((res_tag == CW'(i)) || (res_mispred && yng_q[res_tag][i]));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[i]  <= 1'b0;
        mask_q[i] <= '0;
        yng_q[i]  <= '0;
      end else begin
        if (new_i)       act_q[i] <= 1'b1;
        else if (kill_i) act_q[i] <= 1'b0;
        mask_q[i] <= new_i ? '0 : (mask_q[i] | alloc_hot);
        if (new_i)                  yng_q[i] <= '0;
        else if (act_q[i] && take)  yng_q[i] <= yng_q[i] | slot_hot;
      end
    end

    always_ff @(posedge clk) begin
      if (new_i) map_q[i] <= snap_map;
    end
  end
endmodule

// File: rtl/rename_ckpt_map.sv
module rename_ckpt_map #(
  parameter int unsigned ARCH_REGS = rmap_pkg::DEF_ARCH,
  parameter int unsigned PHYS_REGS = rmap_pkg::DEF_PHYS,
  parameter int unsigned NUM_CKPT  = rmap_pkg::DEF_CKPT,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS),
  localparam int unsigned CW = $clog2(NUM_CKPT),
  localparam int unsigned MW = ARCH_REGS * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic          ren_wr,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_src1,
  output logic [PW-1:0] rsp_src2,
  output logic          rsp_dst_vld,
  output logic [PW-1:0] rsp_dst,
  output logic [PW-1:0] rsp_old,
  input  logic          free_valid,
  input  logic [PW-1:0] free_preg,
  input  logic          br_valid,
  output logic          br_ready,
  output logic          br_ack_valid,
  output logic [CW-1:0] br_ack_tag,
  input  logic          res_valid,
  input  logic [CW-1:0] res_tag,
  input  logic          res_mispred
);
  logic [PW-1:0]        map_q [ARCH_REGS];
  logic [MW-1:0]        snap_flat, restore_flat;
  logic [PW-1:0]        pick_idx;
  logic [PHYS_REGS-1:0] pick_hot, give_hot, reclaim, free_mask, alloc_hot;
  logic                 pick_any, slot_any, flush, ren_fire, wr_fire, br_fire;
  logic [CW-1:0]        slot_idx;
  logic [NUM_CKPT-1:0]  ck_act;

  assign flush     = res_valid && res_mispred;
  assign ren_ready = !flush && (!ren_wr || pick_any);
  assign ren_fire  = ren_valid && ren_ready;
  assign wr_fire   = ren_fire && ren_wr;
  assign br_ready  = !flush && slot_any;
  assign br_fire   = br_valid && br_ready;
  assign give_hot  = free_valid ? (PHYS_REGS'(1) << free_preg) : '0;
  assign alloc_hot = wr_fire ? pick_hot : '0;

  rmap_freelist #(.ARCH(ARCH_REGS), .PHYS(PHYS_REGS)) u_free (
    .clk       (clk),
    .rst       (rst),
    .take      (wr_fire),
    .give_hot  (give_hot),
    .reclaim   (reclaim),
    .pick_idx  (pick_idx),
    .pick_hot  (pick_hot),
    .pick_any  (pick_any),
    .free_mask (free_mask)
  );

  rmap_ckpt_bank #(.ARCH(ARCH_REGS), .PHYS(PHYS_REGS), .NCK(NUM_CKPT)) u_ckpt (
    .clk         (clk),
    .rst         (rst),
    .take        (br_fire),
    .snap_map    (snap_flat),
    .alloc_hot   (alloc_hot),
    .res_valid   (res_valid),
    .res_tag     (res_tag),
    .res_mispred (res_mispred),
    .slot_any    (slot_any),
    .slot_idx    (slot_idx),
    .restore_map (restore_flat),
    .reclaim     (reclaim),
    .active      (ck_act)
  );

  // Map table entries; the snapshot includes a same-cycle rename.
  for (genvar i = 0; i < ARCH_REGS; i++) begin : g_map
    logic hit;
    assign hit = wr_fire && (ren_dst == AW'(i));
    assign snap_flat[i*PW +: PW] = hit ? pick_idx : map_q[i];

    always_ff @(posedge clk) begin
      if (rst)        map_q[i] <= PW'(i);
      else if (flush) map_q[i] <= restore_flat[i*PW +: PW];
      else if (hit)   map_q[i] <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_src1     <= '0;
      rsp_src2     <= '0;
      rsp_dst_vld  <= 1'b0;
      rsp_dst      <= '0;
      rsp_old      <= '0;
      br_ack_valid <= 1'b0;
      br_ack_tag   <= '0;
    end else begin
      rsp_valid    <= ren_fire;
      br_ack_valid <= br_fire;
      if (ren_fire) begin
        rsp_src1    <= map_q[ren_src1];
        rsp_src2    <= map_q[ren_src2];
        rsp_dst_vld <= ren_wr;
        rsp_dst     <= ren_wr ? pick_idx : '0;
        rsp_old     <= ren_wr ? map_q[ren_dst] : '0;
      end
      if (br_fire) br_ack_tag <= slot_idx;
    end
  end
endmodule

// File: rtl/rename_ckpt_map_chk.sv
module rename_ckpt_map_chk #(
  parameter int unsigned PHYS = 64,
  parameter int unsigned NCK  = 4,
  localparam int unsigned PW  = $clog2(PHYS)
) (
  input logic            clk,
  input logic            rst,
  input logic            ren_valid,
  input logic            ren_wr,
  input logic            ren_ready,
  input logic            rsp_valid,
  input logic            rsp_dst_vld,
  input logic [PW-1:0]   rsp_dst,
  input logic            br_valid,
  input logic            br_ready,
  input logic            br_ack_valid,
  input logic            res_valid,
  input logic            res_mispred,
  input logic [PHYS-1:0] free_mask,
  input logic [NCK-1:0]  ck_act
);
  logic [PHYS-1:0] free_d;
  always_ff @(posedge clk) free_d <= free_mask;

  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_ready) |=> rsp_valid);

  a_r4_no_alloc_when_empty: assert property (@(posedge clk) disable iff (rst)
    (ren_ready && ren_wr) |-> (|free_mask));

  a_r3_dst_was_free: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst_vld) |-> free_d[rsp_dst]);

  a_r3_dst_now_taken: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst_vld) |-> !free_mask[rsp_dst]);

  a_r6_full_stall: assert property (@(posedge clk) disable iff (rst)
    (&ck_act) |-> !br_ready);

  a_r6_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_ready) |=> br_ack_valid);

  a_r10_flush_blocks: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mispred) |-> (!ren_ready && !br_ready));
endmodule

bind rename_ckpt_map rename_ckpt_map_chk #(.PHYS(PHYS_REGS), .NCK(NUM_CKPT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ren_valid    (ren_valid),
  .ren_wr       (ren_wr),
  .ren_ready    (ren_ready),
  .rsp_valid    (rsp_valid),
  .rsp_dst_vld  (rsp_dst_vld),
  .rsp_dst      (rsp_dst),
  .br_valid     (br_valid),
  .br_ready     (br_ready),
  .br_ack_valid (br_ack_valid),
  .res_valid    (res_valid),
  .res_mispred  (res_mispred),
  .free_mask    (free_mask),
  .ck_act       (ck_act)
);

// File: tb/rename_ckpt_map_bench.sv
module rename_ckpt_map_bench;
  localparam int A = 32, P = 64, K = 4;
  localparam int AW = $clog2(A), PW = $clog2(P), CW = $clog2(K);

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic ren_valid = 0, ren_wr = 0, ren_ready;
  logic [AW-1:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic rsp_valid, rsp_dst_vld;
  logic [PW-1:0] rsp_src1, rsp_src2, rsp_dst, rsp_old;
  logic free_valid = 0;
  logic [PW-1:0] free_preg = '0;
  logic br_valid = 0, br_ready, br_ack_valid;
  logic [CW-1:0] br_ack_tag;
  logic res_valid = 0, res_mispred = 0;
  logic [CW-1:0] res_tag = '0;

  rename_ckpt_map u_rename_ckpt_map (.*);

  // Reference model
  int m_map [A];
  logic [P-1:0] m_free;
  bit ck_act [K];
  int ck_map [K][A];
  logic [P-1:0] ck_mask [K];
  int ck_seq [K];
  int seqc;
  bit e_rsp, e_dv, e_ack;
  int e_s1, e_s2, e_d, e_old, e_tag;
  int pendq [$];
  int n_chk = 0, n_bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free(logic [P-1:0] v);
    for (int i = 0; i < P; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int lowest_slot();
    for (int k = 0; k < K; k++) if (!ck_act[k]) return k;
    return -1;
  endfunction

  function automatic int n_active();
    int n = 0;
    for (int k = 0; k < K; k++) if (ck_act[k]) n++;
    return n;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < A; i++) m_map[i] = i;
    for (int i = 0; i < P; i++) m_free[i] = (i >= A);
    for (int k = 0; k < K; k++) begin ck_act[k] = 0; ck_mask[k] = '0; end
    e_rsp = 0; e_ack = 0; seqc = 0;
    pendq.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ren_valid = 0; free_valid = 0; br_valid = 0; res_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic step(bit rv, bit rw, int s1, int s2, int d, bit fv, int fp,
                      bit bv, bit resv, int rt, bit rm);
    bit flush, x_rr, x_br, nck;
    int a, slot;
    @(negedge clk);
    chk(rsp_valid == e_rsp, "R1/R3", "rsp_valid", rsp_valid, e_rsp);
    if (e_rsp && rsp_valid) begin
      chk(int'(rsp_src1) == e_s1, "R2/R7", "rsp_src1", rsp_src1, e_s1);
      chk(int'(rsp_src2) == e_s2, "R2/R7", "rsp_src2", rsp_src2, e_s2);
      chk(rsp_dst_vld == e_dv, "R3", "rsp_dst_vld", rsp_dst_vld, e_dv);
      chk(int'(rsp_dst) == e_d, "R3/R5/R8", "rsp_dst", rsp_dst, e_d);
      chk(int'(rsp_old) == e_old, "R3/R7", "rsp_old", rsp_old, e_old);
    end
    chk(br_ack_valid == e_ack, "R6", "br_ack_valid", br_ack_valid, e_ack);
    if (e_ack && br_ack_valid)
      chk(int'(br_ack_tag) == e_tag, "R6/R9", "br_ack_tag", br_ack_tag, e_tag);

    ren_valid = rv; ren_wr = rw; ren_src1 = AW'(s1); ren_src2 = AW'(s2);
    ren_dst = AW'(d); free_valid = fv; free_preg = PW'(fp);
    br_valid = bv; res_valid = resv; res_tag = CW'(rt); res_mispred = rm;
    #1;
    flush = resv && rm;
    x_rr = !flush && (!rw || m_free != '0);
    x_br = !flush && (lowest_slot() >= 0);
    chk(ren_ready == x_rr, flush ? "R10" : "R4", "ren_ready", ren_ready, x_rr);
    chk(br_ready == x_br, flush ? "R10" : "R6", "br_ready", br_ready, x_br);

    e_rsp = rv && x_rr;
    e_ack = 0;
    nck = (n_active() == 0);
    if (e_rsp) begin
      e_s1 = m_map[s1]; e_s2 = m_map[s2]; e_dv = rw;
      e_d = 0; e_old = 0;
      if (rw) begin a = lowest_free(m_free); e_d = a; e_old = m_map[d]; end
    end
    if (flush) begin
      int sq = ck_seq[rt];
      for (int i = 0; i < A; i++) m_map[i] = ck_map[rt][i];
      m_free |= ck_mask[rt];
      for (int k = 0; k < K; k++) if (ck_act[k] && ck_seq[k] >= sq) ck_act[k] = 0;
    end else begin
      slot = lowest_slot();
      if (e_rsp && rw) begin
        m_map[d] = a; m_free[a] = 0;
        for (int k = 0; k < K; k++) if (ck_act[k]) ck_mask[k][a] = 1'b1;
        if (nck) pendq.push_back(e_old);
      end
      if (bv && x_br) begin
        ck_act[slot] = 1; ck_mask[slot] = '0; ck_seq[slot] = seqc++;
        for (int i = 0; i < A; i++) ck_map[slot][i] = m_map[i];
        e_ack = 1; e_tag = slot;
      end
      if (resv) ck_act[rt] = 0;
    end
    if (fv) m_free[fp] = 1'b1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", wd, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    do_reset();
    idle();
    // R1/R2/R3: identity map, source equal to destination sees old value
    step(1, 1, 5, 7, 5, 0, 0, 0, 0, 0, 0);
    step(1, 0, 5, 9, 0, 0, 0, 0, 0, 0, 0);
    // R5: commit frees 5, next allocation picks it
    step(0, 0, 0, 0, 0, 1, 5, 0, 0, 0, 0);
    step(1, 1, 9, 9, 9, 0, 0, 0, 0, 0, 0);
    // R4: drain the free mask, then a writing rename stalls
    for (int i = 0; i < 31; i++) step(1, 1, i, 31 - i, i, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 2, 3, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 2, 3, 0, 0, 0, 0, 0, 0);
    idle();
    // R6: fill all checkpoints, fifth branch stalls
    do_reset();
    for (int k = 0; k < K; k++) step(1, 1, k, k + 1, k, 0, 0, 1, 0, 0, 0);
    step(1, 1, 4, 4, 4, 0, 0, 1, 0, 0, 0);
    // R9: correct resolve of slot 0 frees it; next branch reuses it
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 1, 6, 0, 6, 0, 0, 1, 0, 0, 0);
    // R10 and R7/R8: mispredict slot 1 with a rename offered in the same cycle
    step(1, 1, 1, 2, 2, 0, 0, 1, 1, 1, 1);
    for (int i = 0; i < 6; i++) step(1, 1, i, i + 1, i, 0, 0, 0, 0, 0, 0);
    idle();
    // Random rounds, each from reset
    for (int r = 0; r < 20; r++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        bit rv, rw, fv, bv, resv, rm;
        int fp, rt;
        rv = ($urandom % 4) != 0;
        rw = ($urandom % 4) != 0;
        fv = 0; fp = 0;
        if (n_active() == 0 && pendq.size() > 0 && ($urandom % 3) == 0) begin
          fv = 1; fp = pendq.pop_front();
        end
        bv = ($urandom % 5) == 0;
        resv = 0; rm = 0; rt = 0;
        if (n_active() > 0 && ($urandom % 4) == 0) begin
          rt = $urandom % K;
          while (!ck_act[rt]) rt = (rt + 1) % K;
          resv = 1; rm = ($urandom % 3) == 0;
        end
        step(rv, rw, $urandom % A, $urandom % A, $urandom % A, fv, fp, bv, resv, rt, rm);
      end
      idle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule